// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a small status byte that tells firmware why the chip last came out of reset or left its low-power stop state. Event strobes for power-on reset, watchdog timeout and pin-triggered stop-mode recovery come in together with a level that says whether the part is in stop mode. The raw external reset pin is also an input. It is synchronised, then passed through a minimum-width filter before it counts as an event. Each event sets some flags and clears others, so the flags that survive together identify the cause.

Software reaches the byte through a simple register port with address, read strobe and write strobe. A read at the status address returns the byte in the same cycle, and the four flag bits are cleared on the next clock edge. The address is shared with a write-only watchdog control register. A write there is passed straight to the control outputs and leaves the flags alone.

Top module: `rst_cause_reg`

## Requirements
- R1: After rst_ni is released the status byte reads 0x80. Bit 7 is the power-on flag, bit 6 the stop-recovery flag, bit 5 the watchdog flag and bit 4 the external-pin flag. Bits 3 to 0 always read 0.
- R2: A read (rd_i=1 with addr_i equal to STAT_ADDR) drives rdata_o with the status byte in the same cycle and clears bits 7 to 4 on the following edge. A read at any other address returns 0 and clears nothing.
- R3: A power-on strobe (por_evt_i) sets the byte to exactly 0x80 on the next edge. This overrides every other event in that cycle.
- R4: A watchdog timeout (wdt_evt_i) while stop_i=0 sets bit 5 and clears bits 7 and 6.
- R5: A watchdog timeout while stop_i=1 sets bits 5 and 6 and clears bit 7.
- R6: A pin-triggered stop-mode recovery strobe (smr_evt_i) sets bit 6 and clears bits 7 and 5.
- R7: ext_rst_ni passes through SYNC flops. It then produces one event only once it has been low for MIN_W consecutive cycles, and a shorter low pulse is ignored. The event sets bit 4. If stop_i=1 when the event arrives, it also acts as a pin recovery: bit 6 is set and bits 7 and 5 are cleared.
- R8: A write (wr_i=1 at STAT_ADDR) drives wdt_ctl_wr_o=1 and wdt_ctl_o=wdata_i in the same cycle and leaves the status flags unchanged. A write at another address keeps wdt_ctl_wr_o at 0.
- R9: When a read and an event fall in the same cycle, the read returns the old byte. The event's flag changes take priority over the read-clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| por_evt_i | input | 1 | Power-on reset strobe |
| wdt_evt_i | input | 1 | Watchdog timeout strobe |
| smr_evt_i | input | 1 | Pin-change stop-mode recovery strobe |
| stop_i | input | 1 | Part is in stop mode |
| ext_rst_ni | input | 1 | Raw external reset pin, active low |
| addr_i | input | AW | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0 when not reading status |
| wdt_ctl_o | output | 8 | Watchdog control data |
| wdt_ctl_wr_o | output | 1 | Watchdog control write strobe |

## Verification
The watchdog strobe is applied with stop_i at both levels, and also after a stop recovery has already been flagged. Together these separate the run-time timeout case from the timeout that ends stop mode. Pin recovery after a timeout, and a power-on strobe on top of accumulated flags, show which flag clears which. External pin pulses one cycle shorter than the filter width and exactly at the width check the threshold, and a qualifying pulse during stop checks that it also acts as a recovery. Reads at other addresses, writes that hit the shared address and a read that coincides with a timeout confirm that only a real status read clears the flags, and that it never loses a new event.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  // Bit order matches status byte [7:4]
  typedef struct packed {
    logic por;
    logic stp;
    logic wdt;
    logic ext;
  } cause_t;

  localparam int unsigned NFLAG = 4;
  localparam int unsigned B_POR = 3;
  localparam int unsigned B_STP = 2;
  localparam int unsigned B_WDT = 1;
  localparam int unsigned B_EXT = 0;

  function automatic logic [7:0] cause_byte(cause_t c);
    return {c, 4'b0000};
  endfunction
endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int unsigned MIN_W = 4,
  parameter int unsigned SYNC  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic evt_o
);
  localparam int unsigned CW = $clog2(MIN_W + 1);
  localparam logic [CW-1:0] LIM    = CW'(MIN_W);
  localparam logic [CW-1:0] LIM_M1 = CW'(MIN_W - 1);

  logic [SYNC-1:0] sync_q;
  logic [CW-1:0]   cnt_q;
  logic            evt_q;
  logic            low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC-2:0], pin_ni};
  end

  assign low = ~sync_q[SYNC-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      evt_q <= 1'b0;
    end else begin
      evt_q <= low && (cnt_q == LIM_M1);
      if (!low)             cnt_q <= '0;
      else if (cnt_q < LIM) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign evt_o = evt_q;

  // R7: one event per qualifying low period
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |=> !evt_q);
  // R7: a high synchronised pin never yields an event
  a_r7_high_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !low |=> !evt_q);
endmodule

// File: rtl/rst_cause_flags.sv
module rst_cause_flags
  import rst_cause_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   por_i,
  input  logic   wdt_i,
  input  logic   smr_i,
  input  logic   ext_i,
  input  logic   stop_i,
  input  logic   rd_clr_i,
  output cause_t flags_o
);
  logic [NFLAG-1:0] q, d, set_v, clr_v;
  logic recov_pin, wdt_stop, wdt_run;

  assign recov_pin = smr_i | (ext_i & stop_i);
  assign wdt_stop  = wdt_i & stop_i;
  assign wdt_run   = wdt_i & ~stop_i;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    clr_v[B_POR] = wdt_i | recov_pin;
    set_v[B_STP] = wdt_stop | recov_pin;
    clr_v[B_STP] = wdt_run;
    set_v[B_WDT] = wdt_i;
    clr_v[B_WDT] = recov_pin;
    set_v[B_EXT] = ext_i;
  end

  // Events win over read-clear; sets win over clears
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_comb begin
      if (por_i)                    d[i] = (i == B_POR);
      else if (set_v[i])            d[i] = 1'b1;
      else if (clr_v[i] | rd_clr_i) d[i] = 1'b0;
      else                          d[i] = q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= 4'b1000;
    else         q <= d;
  end

  assign flags_o = cause_t'(q);

  a_r3_por_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (q == 4'b1000));
  a_r4_wdt_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_i && !stop_i && !por_i && !recov_pin) |=> (q[B_WDT] && !q[B_STP] && !q[B_POR]));
  a_r5_wdt_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_i && stop_i && !por_i) |=> (q[B_WDT] && q[B_STP] && !q[B_POR]));
  a_r6_smr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smr_i && !por_i && !wdt_i) |=> (q[B_STP] && !q[B_WDT] && !q[B_POR]));
  a_r9_event_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && wdt_i && !por_i) |=> q[B_WDT]);
  a_r2_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !por_i && !wdt_i && !smr_i && !ext_i) |=> (q == '0));
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_cause_pkg::*;
#(
  parameter int unsigned AW        = 4,
  parameter logic [AW-1:0] STAT_ADDR = '0,
  parameter int unsigned MIN_W     = 4,
  parameter int unsigned SYNC      = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          por_evt_i,
  input  logic          wdt_evt_i,
  input  logic          smr_evt_i,
  input  logic          stop_i,
  input  logic          ext_rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic [7:0]    wdt_ctl_o,
  output logic          wdt_ctl_wr_o
);
  logic   hit, rd_hit, wr_hit, ext_evt;
  cause_t flags;

  assign hit    = (addr_i == STAT_ADDR);
  assign rd_hit = rd_i & hit;
  assign wr_hit = wr_i & hit;

  rst_pin_filter #(.MIN_W(MIN_W), .SYNC(SYNC)) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_ni(ext_rst_ni),
    .evt_o (ext_evt)
  );

  rst_cause_flags u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .por_i   (por_evt_i),
    .wdt_i   (wdt_evt_i),
    .smr_i   (smr_evt_i),
    .ext_i   (ext_evt),
    .stop_i  (stop_i),
    .rd_clr_i(rd_hit),
    .flags_o (flags)
  );

  assign rdata_o      = rd_hit ? cause_byte(flags) : 8'h00;
  assign wdt_ctl_o    = wdata_i;
  assign wdt_ctl_wr_o = wr_hit;

  // R8: a control write leaves the flags untouched
  a_r8_wr_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && !rd_i && !por_evt_i && !wdt_evt_i && !smr_evt_i && !ext_evt)
      |=> $stable(flags));
  // R2: reads elsewhere do not clear
  a_r2_other_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !hit && !por_evt_i && !wdt_evt_i && !smr_evt_i && !ext_evt)
      |=> $stable(flags));
  // R7: filtered pin event sets its flag
  a_r7_ext_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_evt && !por_evt_i) |=> flags.ext);
endmodule

// File: tb/rst_cause_reg_tb.sv
module rst_cause_reg_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       por_evt_i = 0, wdt_evt_i = 0, smr_evt_i = 0, stop_i = 0;
  logic       ext_rst_ni = 1'b1;
  logic [3:0] addr_i = '0;
  logic       rd_i = 0, wr_i = 0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o, wdt_ctl_o;
  logic       wdt_ctl_wr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk_i = ~clk_i;

  rst_cause_reg u_dut (
    .clk_i, .rst_ni, .por_evt_i, .wdt_evt_i, .smr_evt_i, .stop_i, .ext_rst_ni,
    .addr_i, .rd_i, .wr_i, .wdata_i, .rdata_o, .wdt_ctl_o, .wdt_ctl_wr_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  task automatic evt(input bit p, input bit w, input bit s, input bit st);
    tick();
    por_evt_i = p; wdt_evt_i = w; smr_evt_i = s; stop_i = st;
    tick();
    por_evt_i = 0; wdt_evt_i = 0; smr_evt_i = 0; stop_i = 0;
  endtask

  // Driver: pushes expected byte, monitor compares
  task automatic rd_exp(input logic [7:0] e, input string tag, input bit with_wdt = 0);
    tick();
    addr_i = 4'h0; rd_i = 1; wdt_evt_i = with_wdt;
    exp_q.push_back(e); tag_q.push_back(tag);
    tick();
    rd_i = 0; wdt_evt_i = 0;
  endtask

  task automatic ext_pulse(input int len, input bit st);
    tick();
    stop_i = st; ext_rst_ni = 0;
    repeat (len) tick();
    ext_rst_ni = 1;
    repeat (6) tick();
    stop_i = 0;
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && rd_i && addr_i == 4'h0) begin
      if (exp_q.size() == 0) chk(0, "R2 unexpected read", rdata_o, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(rdata_o === e, t, rdata_o, e);
      end
    end
  end

  initial begin
    #(20 * 20000);
    chk(0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1;
    // R2: other address returns 0, no clear
    tick(); addr_i = 4'h3; rd_i = 1;
    @(negedge clk_i); chk(rdata_o === 8'h00, "R2 other addr read", rdata_o, 0);
    tick(); rd_i = 0; addr_i = 0;
    rd_exp(8'h80, "R1 reset value");
    rd_exp(8'h00, "R2 read clears");
    evt(0, 0, 1, 0);  rd_exp(8'h40, "R6 smr sets stop");
    evt(0, 1, 0, 1);  rd_exp(8'h60, "R5 wdt in stop");
    evt(0, 0, 1, 0);  evt(0, 1, 0, 0); rd_exp(8'h20, "R4 wdt clears stop");
    evt(1, 0, 0, 0);  rd_exp(8'h80, "R3 por");
    evt(1, 0, 0, 0);  evt(0, 1, 0, 0); rd_exp(8'h20, "R4 wdt clears por");
    evt(0, 1, 0, 0);  evt(0, 0, 1, 0); rd_exp(8'h40, "R6 smr clears wdt");
    ext_pulse(3, 0);  rd_exp(8'h00, "R7 short pulse ignored");
    ext_pulse(4, 0);  rd_exp(8'h10, "R7 min width pulse");
    evt(0, 1, 0, 0);  ext_pulse(4, 1); rd_exp(8'h50, "R7 pin in stop");
    evt(0, 1, 0, 1);  ext_pulse(5, 0); evt(1, 0, 0, 0);
    rd_exp(8'h80, "R3 por clears all");
    // R8: shared-address write
    evt(0, 0, 1, 0);
    tick(); addr_i = 4'h0; wr_i = 1; wdata_i = 8'hA5;
    @(negedge clk_i);
    chk(wdt_ctl_wr_o === 1'b1, "R8 ctl strobe", wdt_ctl_wr_o, 1);
    chk(wdt_ctl_o === 8'hA5, "R8 ctl data", wdt_ctl_o, 8'hA5);
    tick(); addr_i = 4'h5;
    @(negedge clk_i);
    chk(wdt_ctl_wr_o === 1'b0, "R8 other addr write", wdt_ctl_wr_o, 0);
    tick(); wr_i = 0; addr_i = 0;
    rd_exp(8'h40, "R8 write keeps flags");
    // R9: read and event together
    evt(0, 0, 1, 0);
    rd_exp(8'h40, "R9 read returns old", 1);
    rd_exp(8'h20, "R9 event survives clear");
    repeat (3) tick();
    chk(exp_q.size() == 0, "R2 all reads seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule